// File: doc/BRIEF.md
# Transmit Packet Assembler with Line Coding

This block builds a complete transmit packet and shifts it out one chip at a time. It holds the payload in an internal 64-byte transmit queue that the host fills a byte per cycle. When a start pulse arrives, it walks through a fixed chain of fields: a preamble of alternating bits, a sync word of one to four bytes, an optional header of up to four bytes, an optional length byte, the payload taken from the queue, and an optional CRC-16. A field with a count of zero is skipped. Data whitening can be applied to the payload and the CRC. Manchester coding can be applied to the whole packet, with an option to flip the chip polarity.

Timing comes from an external data-rate strobe: each `bit_tick` pulse advances the serial output by exactly one chip. The block signals the end of a good packet with a one-cycle pulse. It signals a queue underrun with its own pulse, and it raises events when the queue fill level crosses two programmable thresholds. If the host issues another start without writing to the queue, the block sends the previous packet again.

Top module: `tx_packet_assembler`

## Requirements
- R1: The preamble is `pre_len` bytes of alternating bits that start with a 0 (each byte is 0x55). A `pre_len` of 0 omits the preamble.
- R2: The sync word holds `sync_len`+1 bytes. Byte n of the sync word is `sync_word[8n+7:8n]`. The bytes are sent from n=`sync_len` down to n=0.
- R3: After the sync word come `hdr_len` header bytes (0..4), sent from `hdr_word` byte `hdr_len`-1 down to byte 0. When `len_en`=1, a length byte equal to `pkt_len` follows the header.
- R4: The block sends exactly `pkt_len` payload bytes, popped in order from the queue. Every byte of every field goes out most significant bit first. On the clock edge that emits the final chip, `pkt_sent` pulses for one cycle and `busy` falls. Output then holds until the next `start`.
- R5: When `crc_en`=1, a CRC-16 follows the payload, high byte first. The CRC uses polynomial 0x1021 and seed 0xFFFF and is computed over the unwhitened bits. With `crc_all`=1 it covers the header, the length byte and the payload; with `crc_all`=0 it covers the payload only.
- R6: When `wh_en`=1, each payload and CRC bit is XORed with s[0] of a 9-bit generator s. After each such bit, s becomes {s[0]^s[5], s[8:1]}. The generator is set to all ones at the first payload bit.
- R7: When `man_en`=1, every data bit d of the packet is sent as two chips, d^`man_inv` and then ~d^`man_inv`. When `man_en`=0, each data bit is one chip and `man_inv` is ignored.
- R8: `tx_bit` changes only on a `bit_tick` cycle while `busy` is high. The first chip appears on the first tick after `start`. After reset, `tx_bit`, `busy`, `pkt_sent` and `err_underflow` are all 0.
- R9: The queue holds 64 bytes. A write while the queue is full is dropped.
- R10: `ev_afull` pulses for one cycle when the fill level rises above `afull_thr`. `ev_aempty` pulses for one cycle when the fill level falls to or below `aempty_thr`.
- R11: A `start` that follows a completed packet, with no queue write accepted since the previous `start`, sends the same payload again.
- R12: If a payload byte is due while the queue is empty, `err_underflow` pulses for one cycle, `busy` falls, and `pkt_sent` is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_wr | input | 1 | Queue write strobe |
| fifo_wdata | input | 8 | Queue write byte |
| afull_thr | input | 6 | Almost-full threshold in bytes |
| aempty_thr | input | 6 | Almost-empty threshold in bytes |
| start | input | 1 | Start a packet (ignored while busy) |
| bit_tick | input | 1 | Chip-rate strobe |
| pre_len | input | 4 | Preamble bytes |
| sync_len | input | 2 | Sync bytes minus one |
| sync_word | input | 32 | Sync value |
| hdr_len | input | 3 | Header bytes, 0..4 |
| hdr_word | input | 32 | Header value |
| len_en | input | 1 | Insert length byte |
| pkt_len | input | 8 | Payload bytes |
| crc_en | input | 1 | Append CRC |
| crc_all | input | 1 | CRC covers header and length too |
| wh_en | input | 1 | Whiten payload and CRC |
| man_en | input | 1 | Manchester coding |
| man_inv | input | 1 | Flip Manchester chips |
| tx_bit | output | 1 | Serial chip output |
| busy | output | 1 | Packet in progress |
| pkt_sent | output | 1 | Packet completed pulse |
| err_underflow | output | 1 | Queue ran dry pulse |
| ev_afull | output | 1 | Almost-full crossing pulse |
| ev_aempty | output | 1 | Almost-empty crossing pulse |

## Verification
Two events share one cycle. When the last payload bit is emitted, the CRC accumulates that bit, and on the same edge the CRC high byte is loaded for sending. The other case is the final data bit of a payload byte meeting an empty queue, where that bit still goes out on the same edge that raises the underrun. The first case is driven by every vector that has CRC enabled. It is judged by comparing every chip against a CRC the bench computes itself, with both whitening and Manchester coding switched on and off. The second case is driven by asking for 65 bytes from a queue filled with 64 plus one overflow write. It is judged by counting exactly 528 matching chips, one underrun pulse and no completion.

// File: rtl/txp_pkg.sv
package txp_pkg;
   typedef enum logic [2:0] {
      F_PRE  = 3'd0,
      F_SYNC = 3'd1,
      F_HDR  = 3'd2,
      F_LEN  = 3'd3,
      F_PAY  = 3'd4,
      F_CRC  = 3'd5,
      F_END  = 3'd6
   } field_e;

   typedef struct packed {
      field_e     f;
      logic [8:0] i;
   } pos_t;

   function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
      return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
   endfunction

   function automatic logic [8:0] pn_step(logic [8:0] s);
      return {s[0] ^ s[5], s[8:1]};
   endfunction

   // Skip forward past any field whose byte count is used up or zero.
   function automatic pos_t seek(pos_t p, logic [53:0] cnts);
      pos_t q = p;
      for (int k = 0; k < 6; k++) begin
         if (q.f != F_END && q.i >= cnts[int'(q.f)*9 +: 9]) begin
            q.f = field_e'(q.f + 3'd1);
            q.i = '0;
         end
      end
      return q;
   endfunction
endpackage

// File: rtl/txp_fifo.sv
module txp_fifo #(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   input  logic          pop,
   output logic [7:0]    rd_data,
   output logic          empty,
   input  logic          start,
   input  logic          pkt_done,
   input  logic [AW-1:0] afull_thr,
   input  logic [AW-1:0] aempty_thr,
   output logic          ev_afull,
   output logic          ev_aempty
);
   logic [7:0]  mem [DEPTH];
   logic [AW:0] wp, rp, base, fill;
   logic        dirty, last_ok, af_q, ae_q, full, wr_acc, af_lvl, ae_lvl;

   assign fill    = wp - rp;
   assign full    = (fill == (AW+1)'(DEPTH));
   assign empty   = (fill == '0);
   assign wr_acc  = wr_en && !full;
   assign rd_data = mem[rp[AW-1:0]];
   assign af_lvl  = fill > {1'b0, afull_thr};
   assign ae_lvl  = fill <= {1'b0, aempty_thr};
   assign ev_afull  = af_lvl && !af_q;
   assign ev_aempty = ae_lvl && !ae_q;

   always_ff @(posedge clk) begin
      if (wr_acc) mem[wp[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; base <= '0;
         dirty <= 1'b1; last_ok <= 1'b0;
         af_q <= 1'b0; ae_q <= 1'b1;
      end else begin
         af_q <= af_lvl;
         ae_q <= ae_lvl;
         if (wr_acc) wp <= wp + 1'b1;
         if (start) dirty <= wr_acc;
         else if (wr_acc) dirty <= 1'b1;
         if (start) last_ok <= 1'b0;
         else if (pkt_done) last_ok <= 1'b1;
         if (start && !dirty && last_ok) begin
            rp <= base;
         end else begin
            if (start) base <= rp;
            if (pop) rp <= rp + 1'b1;
         end
      end
   end

   p_fill_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= (AW+1)'(DEPTH));
   p_pop_nonempty_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/txp_framer.sv
module txp_framer
   import txp_pkg::*;
#(
   parameter int PRE_W = 4,
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             bit_tick,
   input  logic [PRE_W-1:0] pre_len,
   input  logic [1:0]       sync_len,
   input  logic [31:0]      sync_word,
   input  logic [2:0]       hdr_len,
   input  logic [31:0]      hdr_word,
   input  logic             len_en,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             crc_en,
   input  logic             crc_all,
   input  logic             wh_en,
   input  logic             man_en,
   input  logic             man_inv,
   input  logic [7:0]       fifo_data,
   input  logic             fifo_empty,
   output logic             pop,
   output logic             tx_bit,
   output logic             busy,
   output logic             pkt_sent,
   output logic             err_underflow
);
   field_e      fld;
   logic [8:0]  idx;
   logic [7:0]  sh;
   logic [2:0]  bcnt;
   logic        phase, in_wh, in_crc, dbit, adv;
   logic [8:0]  pn;
   logic [15:0] crc, crc_nxt;
   logic [2:0]  hdr_n;
   logic [53:0] cnts;
   pos_t        np, p0;

   assign hdr_n = (hdr_len > 3'd4) ? 3'd4 : hdr_len;
   assign cnts  = {9'(crc_en ? 2 : 0), 9'(pkt_len), 9'(len_en), 9'(hdr_n),
                   9'(sync_len) + 9'd1, 9'(pre_len)};
   assign np    = seek('{f: fld, i: idx + 9'd1}, cnts);
   assign p0    = seek('{f: F_PRE, i: 9'd0}, cnts);

   function automatic logic [7:0] fbyte(pos_t p, logic [15:0] c);
      logic [1:0] s;
      logic [2:0] h;
      s = sync_len - p.i[1:0];
      h = hdr_n - 3'd1 - p.i[2:0];
      case (p.f)
         F_PRE:   return 8'h55;
         F_SYNC:  return sync_word[{s, 3'b000} +: 8];
         F_HDR:   return hdr_word[{h[1:0], 3'b000} +: 8];
         F_LEN:   return 8'(pkt_len);
         F_PAY:   return fifo_data;
         F_CRC:   return (p.i == 9'd0) ? c[15:8] : c[7:0];
         default: return 8'h00;
      endcase
   endfunction

   assign in_wh   = wh_en && (fld == F_PAY || fld == F_CRC);
   assign in_crc  = (fld == F_PAY) || (crc_all && (fld == F_HDR || fld == F_LEN));
   assign dbit    = sh[7] ^ (in_wh & pn[0]);
   assign crc_nxt = in_crc ? crc_step(crc, sh[7]) : crc;
   assign adv     = busy && bit_tick && (!man_en || phase);
   assign pop     = adv && bcnt == 3'd7 && np.f == F_PAY && !fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; fld <= F_END; idx <= '0; sh <= '0; bcnt <= '0;
         phase <= 1'b0; pn <= '1; crc <= '1; tx_bit <= 1'b0;
         pkt_sent <= 1'b0; err_underflow <= 1'b0;
      end else begin
         pkt_sent <= 1'b0;
         err_underflow <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1; fld <= p0.f; idx <= p0.i;
               sh <= fbyte(p0, 16'hFFFF);
               bcnt <= '0; phase <= 1'b0; pn <= '1; crc <= '1;
            end
         end else if (bit_tick) begin
            tx_bit <= man_en ? (dbit ^ man_inv ^ phase) : dbit;
            if (man_en && !phase) begin
               phase <= 1'b1;
            end else begin
               phase <= 1'b0;
               crc   <= crc_nxt;
               if (in_wh) pn <= pn_step(pn);
               sh   <= {sh[6:0], 1'b0};
               bcnt <= bcnt + 3'd1;
               if (bcnt == 3'd7) begin
                  if (np.f == F_END) begin
                     busy <= 1'b0; pkt_sent <= 1'b1;
                  end else if (np.f == F_PAY && fifo_empty) begin
                     busy <= 1'b0; err_underflow <= 1'b1;
                  end else begin
                     fld <= np.f; idx <= np.i;
                     sh  <= fbyte(np, crc_nxt);
                     if (np.f == F_PAY && np.i == 9'd0) pn <= '1;
                  end
               end
            end
         end
      end
   end

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tx_bit));
   p_manch_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bit_tick && phase) |=> (tx_bit != $past(tx_bit)));
   p_sent_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_sent |-> !busy);
   p_err_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      err_underflow |-> (!busy && !pkt_sent));
endmodule

// File: rtl/tx_packet_assembler.sv
module tx_packet_assembler #(
   parameter int DEPTH = 64,
   parameter int PRE_W = 4,
   parameter int LEN_W = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_wr,
   input  logic [7:0]       fifo_wdata,
   input  logic [AW-1:0]    afull_thr,
   input  logic [AW-1:0]    aempty_thr,
   input  logic             start,
   input  logic             bit_tick,
   input  logic [PRE_W-1:0] pre_len,
   input  logic [1:0]       sync_len,
   input  logic [31:0]      sync_word,
   input  logic [2:0]       hdr_len,
   input  logic [31:0]      hdr_word,
   input  logic             len_en,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             crc_en,
   input  logic             crc_all,
   input  logic             wh_en,
   input  logic             man_en,
   input  logic             man_inv,
   output logic             tx_bit,
   output logic             busy,
   output logic             pkt_sent,
   output logic             err_underflow,
   output logic             ev_afull,
   output logic             ev_aempty
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LEN_W > 8 || PRE_W > 8) begin : g_bad_width
      $error("length and preamble counts must fit one byte");
   end

   logic [7:0] f_data;
   logic       f_empty, f_pop;

   txp_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_data(fifo_wdata),
      .pop(f_pop), .rd_data(f_data), .empty(f_empty),
      .start(start && !busy), .pkt_done(pkt_sent),
      .afull_thr(afull_thr), .aempty_thr(aempty_thr),
      .ev_afull(ev_afull), .ev_aempty(ev_aempty)
   );

   txp_framer #(.PRE_W(PRE_W), .LEN_W(LEN_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .start(start), .bit_tick(bit_tick),
      .pre_len(pre_len), .sync_len(sync_len), .sync_word(sync_word),
      .hdr_len(hdr_len), .hdr_word(hdr_word), .len_en(len_en),
      .pkt_len(pkt_len), .crc_en(crc_en), .crc_all(crc_all),
      .wh_en(wh_en), .man_en(man_en), .man_inv(man_inv),
      .fifo_data(f_data), .fifo_empty(f_empty), .pop(f_pop),
      .tx_bit(tx_bit), .busy(busy), .pkt_sent(pkt_sent),
      .err_underflow(err_underflow)
   );
endmodule

// File: tb/tb_tx_packet_assembler.sv
`timescale 1ns/1ps
module tb_tx_packet_assembler;
   logic clk = 1'b0, rst_n = 1'b0;
   logic fifo_wr = 1'b0, start = 1'b0, bit_tick = 1'b0;
   logic [7:0] fifo_wdata = '0;
   logic [5:0] afull_thr = 6'd3, aempty_thr = 6'd1;
   logic [3:0] pre_len = '0;
   logic [1:0] sync_len = '0;
   logic [2:0] hdr_len = '0;
   logic len_en = 0, crc_en = 0, crc_all = 0, wh_en = 0, man_en = 0, man_inv = 0;
   logic [7:0] pkt_len = '0;
   logic tx_bit, busy, pkt_sent, err_underflow, ev_afull, ev_aempty;

   localparam logic [31:0] SYNC_W = 32'hD391_2DB7;
   localparam logic [31:0] HDR_W  = 32'hA1B2_C3D4;
   // [3:0] pre, [5:4] sync, [8:6] hdr, [9] len, [10] crc, [11] crc_all,
   // [12] whiten, [13] manchester, [14] invert, [22:15] payload length
   localparam int NV = 7;
   localparam logic [22:0] VEC [NV] = '{23'h18012, 23'h286B4, 23'h20F01,
                                        23'h41E63, 23'h33432, 23'h57ED1, 23'h08000};

   always #4 clk = ~clk;

   tx_packet_assembler dut (
      .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
      .afull_thr(afull_thr), .aempty_thr(aempty_thr), .start(start),
      .bit_tick(bit_tick), .pre_len(pre_len), .sync_len(sync_len),
      .sync_word(SYNC_W), .hdr_len(hdr_len), .hdr_word(HDR_W), .len_en(len_en),
      .pkt_len(pkt_len), .crc_en(crc_en), .crc_all(crc_all), .wh_en(wh_en),
      .man_en(man_en), .man_inv(man_inv), .tx_bit(tx_bit), .busy(busy),
      .pkt_sent(pkt_sent), .err_underflow(err_underflow),
      .ev_afull(ev_afull), .ev_aempty(ev_aempty)
   );

   int checks = 0, fails = 0;
   int n_sent = 0, n_err = 0, n_af = 0, n_ae = 0;
   always @(posedge clk) begin
      if (pkt_sent) n_sent <= n_sent + 1;
      if (err_underflow) n_err <= n_err + 1;
      if (ev_afull) n_af <= n_af + 1;
      if (ev_aempty) n_ae <= n_ae + 1;
   end

   logic exp_c [8192];
   int ne;
   logic [7:0] pay [256];
   logic [8:0] m_pn;
   logic [15:0] m_crc;

   task automatic check(input logic ok, input string msg, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", msg, act, expv);
      end
   endtask

   task automatic put_byte(input logic [7:0] b, input logic wh, input logic cr);
      for (int i = 7; i >= 0; i--) begin
         logic d, o;
         d = b[i];
         if (cr) m_crc = {m_crc[14:0], 1'b0} ^ ((m_crc[15] ^ d) ? 16'h1021 : 16'h0);
         o = wh ? (d ^ m_pn[0]) : d;
         if (wh) m_pn = {m_pn[0] ^ m_pn[5], m_pn[8:1]};
         if (man_en) begin
            exp_c[ne] = o ^ man_inv; exp_c[ne+1] = ~o ^ man_inv; ne += 2;
         end else begin
            exp_c[ne] = o; ne++;
         end
      end
   endtask

   task automatic build(input int plen);
      logic [15:0] c;
      ne = 0; m_pn = '1; m_crc = '1;
      for (int i = 0; i < int'(pre_len); i++) put_byte(8'h55, 1'b0, 1'b0);
      for (int i = int'(sync_len); i >= 0; i--) put_byte(SYNC_W[8*i +: 8], 1'b0, 1'b0);
      for (int i = int'(hdr_len) - 1; i >= 0; i--) put_byte(HDR_W[8*i +: 8], 1'b0, crc_all);
      if (len_en) put_byte(pkt_len, 1'b0, crc_all);
      m_pn = '1;
      for (int k = 0; k < plen; k++) put_byte(pay[k], wh_en, 1'b1);
      if (crc_en) begin
         c = m_crc;
         put_byte(c[15:8], wh_en, 1'b0);
         put_byte(c[7:0], wh_en, 1'b0);
      end
   endtask

   task automatic apply(input logic [22:0] v);
      pre_len = v[3:0]; sync_len = v[5:4]; hdr_len = v[8:6]; len_en = v[9];
      crc_en = v[10]; crc_all = v[11]; wh_en = v[12]; man_en = v[13];
      man_inv = v[14]; pkt_len = v[22:15];
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk) fifo_wr = 1'b1; fifo_wdata = b;
      @(negedge clk) fifo_wr = 1'b0;
   endtask

   task automatic fill(input int v, input int n);
      for (int k = 0; k < n; k++) begin
         pay[k] = 8'(k * 29 + v * 7 + 3);
         push(pay[k]);
      end
   endtask

   task automatic tick();
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic run_stream(output int bad);
      bad = 0;
      pulse_start();
      for (int k = 0; k < ne; k++) begin
         tick();
         if (tx_bit !== exp_c[k]) bad++;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int bad, s0, e0, a0, t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check(!busy && !tx_bit && !pkt_sent && !err_underflow, "R8 reset outputs",
            int'({busy, tx_bit, pkt_sent, err_underflow}), 0);
      tick();
      check(!busy && !tx_bit, "R8 idle tick leaves output", int'(tx_bit), 0);

      // R1 R2 R3 R4 R5 R6 R7 across the vector table
      for (int v = 0; v < NV; v++) begin
         apply(VEC[v]);
         fill(v, int'(pkt_len));
         build(int'(pkt_len));
         s0 = n_sent;
         run_stream(bad);
         check(bad == 0 && n_sent == s0 + 1 && !busy,
               $sformatf("vec %0d stream R1 R2 R3 R4 R5 R6 R7 R8 chip errors", v), bad, 0);
      end

      // R11 restart with no new writes resends the same packet
      s0 = n_sent;
      run_stream(bad);
      check(bad == 0 && n_sent == s0 + 1, "R11 retransmit chip errors", bad, 0);

      // R10 threshold crossings (afull_thr 3, aempty_thr 1)
      a0 = n_af; e0 = n_ae;
      apply((VEC[0] & ~(23'hFF << 15)) | (23'd4 << 15));
      fill(9, 4);
      @(negedge clk);
      check(n_af == a0 + 1, "R10 afull event count", n_af - a0, 1);
      check(n_ae == e0, "R10 aempty quiet while filling", n_ae - e0, 0);
      build(4);
      run_stream(bad);
      check(bad == 0, "R10 packet chip errors", bad, 0);
      check(n_ae == e0 + 1, "R10 aempty event count", n_ae - e0, 1);
      check(n_af == a0 + 1, "R10 afull quiet while draining", n_af - a0, 1);

      // R9 write into full queue dropped; R12 underrun ends packet
      apply(23'h208001);
      fill(3, 64);
      push(8'hEE);
      s0 = n_sent; e0 = n_err;
      build(64);
      pulse_start();
      t = 0; bad = 0;
      while (busy && t < 1000) begin
         tick();
         if (t < ne && tx_bit !== exp_c[t]) bad++;
         t++;
      end
      @(negedge clk);
      check(t == ne, "R9 chips before underrun", t, ne);
      check(bad == 0, "R9 queued bytes chip errors", bad, 0);
      check(n_err == e0 + 1, "R12 underflow pulses", n_err - e0, 1);
      check(n_sent == s0, "R12 no completion", n_sent - s0, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule